// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces a pulse-width-modulated output whose repetition rate comes from a phase accumulator instead of a reload counter. On every clock an unsigned increment is added to an N-bit accumulator. Each time the sum carries out of N bits, one PWM period ends. The output frequency is therefore f_clk * increment / 2^N. The duty cycle is set by an 8-bit on-time value. That value is compared against the eight most significant accumulator bits.

A host writes one control word that holds both fields. The word lands in shadow registers. An update strobe arms a transfer into the active registers. The transfer happens at the next accumulator wrap, so the period that is running always finishes unchanged. If the accumulator is stopped, either because the block is disabled or because the active increment is zero, the transfer happens on the next clock instead. An increment of zero freezes the accumulator and holds the output low. Deasserting the enable input forces the output low and returns the accumulator to zero.

Top module: `pacc_pwm`

## Requirements
- R1: While enabled, every rising clock edge adds the active increment to the N-bit accumulator modulo 2^N. When the increment divides 2^N, each period lasts exactly 2^N / increment cycles.
- R2: The output is high exactly when the accumulator's top 8 bits, read as an unsigned number, are below the active on-time. On-time 0 gives a constant low. On-time 255 gives an output that is low in only one of 256 slots.
- R3: When the active increment is 0, the accumulator does not change and the output stays at logic 0, whatever the on-time is.
- R4: In the control word, bits [7:0] are the on-time and bits [N+7:8] are the increment. Any bits above N+7 have no effect on the output.
- R5: A written control word has no effect until the update strobe is given. Once the strobe is given, the new values become active at the edge where the accumulator wraps. That edge uses the old increment to produce the wrapped value, so the period in progress completes with its old timing.
- R6: If an update is pending while the active increment is 0 or the block is disabled, the new values become active on the next clock edge, and the accumulator restarts from 0.
- R7: While the enable input is low, the output is low in that same cycle and the accumulator is cleared at the next edge. After enable returns, counting restarts from 0.
- R8: Reset clears the accumulator, the shadow and active fields, and any pending update, so the output is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the accumulator advances once per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces the output low and clears the accumulator |
| cfg_we | input | 1 | Loads cfg_word into the shadow registers |
| cfg_word | input | CFG_W | Control word: on-time in [7:0], increment in [ACC_W+7:8] |
| upd | input | 1 | Arms the transfer of the shadow values into the active registers |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded assertions check four things on every cycle. The accumulator advances by exactly the active increment unless a commit intervenes. The active fields stay put between wraps while running. A zero increment freezes the accumulator. A disabled block has a low output and an accumulator that clears. Three things can only be shown by the bench scenarios, which compare the output cycle by cycle against a model of the requirements over whole windows: the period length and the high time per period, the exact cycle at which a deferred update lands, and the fact that upper word bits and writes without a strobe leave the waveform unchanged.

// File: rtl/pacc_pwm.sv
module pacc_pwm #(
  parameter int ACC_W  = 16,
  parameter int DUTY_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             upd,
  output logic             pwm_out
);

  localparam int STEP_LSB = DUTY_W;
  localparam int USED_W   = STEP_LSB + ACC_W;

  logic [ACC_W-1:0]  sh_step, step_q, acc_q;
  logic [DUTY_W-1:0] sh_duty, duty_q;
  logic              pend_q;
  logic [ACC_W:0]    sum;
  logic              wrap, commit, step_zero;

  assign sum       = {1'b0, acc_q} + {1'b0, step_q};
  assign wrap      = sum[ACC_W];
  assign step_zero = (step_q == '0);
  assign commit    = pend_q && (!en || step_zero || wrap);

  generate
    if (CFG_W > USED_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^cfg_word[CFG_W-1:USED_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_step <= '0;
      sh_duty <= '0;
    end else if (cfg_we) begin
      sh_step <= cfg_word[STEP_LSB +: ACC_W];
      sh_duty <= cfg_word[DUTY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      duty_q <= '0;
      pend_q <= 1'b0;
    end else if (commit) begin
      step_q <= sh_step;
      duty_q <= sh_duty;
      pend_q <= upd;
    end else if (upd) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              acc_q <= '0;
    else if (!en)            acc_q <= '0;
    else if (commit && !wrap) acc_q <= '0;
    else                     acc_q <= sum[ACC_W-1:0];
  end

  assign pwm_out = en && !step_zero && (acc_q[ACC_W-1 -: DUTY_W] < duty_q);

  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !commit) |=> (acc_q == ACC_W'($past(acc_q) + $past(step_q)))); // R1
  AST_OUT_LOW_DUTY0: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_out); // R2
  AST_ZERO_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_zero && !pend_q) |=> $stable(acc_q)); // R3
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step_zero && !wrap) |=> (step_q == $past(step_q) && duty_q == $past(duty_q))); // R5
  AST_PEND_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(upd)); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (acc_q == '0)); // R7
  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |-> !pwm_out); // R7

endmodule

// File: tb/tb_pacc_pwm.sv
module tb_pacc_pwm;
  localparam int N = 12;
  localparam int MOD = 1 << N;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_we = 1'b0, upd = 1'b0;
  logic [31:0] cfg_word = '0;
  logic pwm_out;
  int checks = 0, errors = 0;
  bit done = 0;

  pacc_pwm #(.ACC_W(N), .DUTY_W(8), .CFG_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
    .cfg_word(cfg_word), .upd(upd), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  function automatic bit exp_out(int unsigned step, int unsigned duty, int unsigned i);
    int unsigned a;
    a = (i * step) % MOD;
    return (step != 0) && ((a >> (N - 8)) < duty);
  endfunction

  function automatic logic [31:0] mkword(int unsigned hi, int unsigned step, int unsigned duty);
    return (hi << (N + 8)) | ((step % MOD) << 8) | (duty & 8'hFF);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] w);
    @(negedge clk); #1 cfg_we = 1'b1; cfg_word = w;
    @(negedge clk); #1 cfg_we = 1'b0; upd = 1'b1;
    @(negedge clk); #1 upd = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_seg(input string req, input int n, input int unsigned step,
                         input int unsigned duty, input int wr_at,
                         input logic [31:0] wr_w, input int upd_at);
    int mism = 0, hi = 0, ehi = 0, ri = 0, eri = 0;
    bit prev = 0, eprev = 0;
    for (int i = 0; i < n; i++) begin
      bit e;
      #1;
      e = exp_out(step, duty, i);
      if (pwm_out !== e) mism++;
      if (pwm_out) hi++;
      if (e) ehi++;
      if (i > 0 && pwm_out && !prev) ri++;
      if (i > 0 && e && !eprev) eri++;
      prev = pwm_out; eprev = e;
      if (i == wr_at) begin cfg_we = 1'b1; cfg_word = wr_w; end
      if (i == wr_at + 1) cfg_we = 1'b0;
      if (i == upd_at) upd = 1'b1;
      if (i == upd_at + 1) upd = 1'b0;
      @(negedge clk);
    end
    chk({req, " waveform mismatches"}, mism, 0);
    chk({req, " high cycles"}, hi, ehi);
    chk({req, " rising edges"}, ri, eri);
  endtask

  initial begin
    int unsigned s, d, h;
    process::self().srandom(32'd1234);
    en = 1'b1;
    #25; #1 chk("R8 output during reset", int'(pwm_out), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R8 output after reset", int'(pwm_out), 0);
    en = 1'b0;

    load(mkword(0, 16, 128)); en = 1'b1;
    run_seg("R1/R2 step16 duty128", 512, 16, 128, -1, '0, -1);
    run_seg("R5 write without strobe", 256, 16, 128, 30, mkword(0, 64, 10), -1);
    run_seg("R5 old period kept", 256, 16, 128, 40, mkword(0, 32, 64), 60);
    run_seg("R5 new values at wrap", 512, 32, 64, -1, '0, -1);

    #1 en = 1'b0;
    #1 chk("R7 output low when disabled", int'(pwm_out), 0);
    repeat (5) @(negedge clk);
    #1 chk("R7 still low while disabled", int'(pwm_out), 0);
    en = 1'b1;
    run_seg("R7 restart from zero", 300, 32, 64, -1, '0, -1);

    en = 1'b0;
    load(mkword(0, 16, 255)); en = 1'b1;
    run_seg("R2 on-time 255", 512, 16, 255, -1, '0, -1);
    en = 1'b0;
    load(mkword(0, 16, 0)); en = 1'b1;
    run_seg("R2 on-time 0", 300, 16, 0, -1, '0, -1);

    en = 1'b0;
    load(mkword(0, 0, 200)); en = 1'b1;
    run_seg("R3 zero step", 200, 0, 200, -1, '0, -1);
    load(mkword(0, 64, 100));
    run_seg("R6 commit from zero step", 256, 64, 100, -1, '0, -1);

    for (int k = 0; k < 8; k++) begin
      s = $urandom % MOD; d = $urandom % 256; h = $urandom % 4096;
      if (k == 2) s = 0;
      if (k == 5) d = 255;
      en = 1'b0;
      load(mkword(h, s, d)); en = 1'b1;
      run_seg("R1/R2/R4 random", 1500, s, d, -1, '0, -1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule